// File: doc/BRIEF.md
# Escalating Watchdog Timer

This block is a per-core watchdog that gets louder the longer software ignores it. A control write selects an escalation mode and a 16-bit length. The length is placed in the upper bits of a wider down-counter, and that counter steps once per prescaler wrap of the I/O clock. Each time the counter runs out, the block advances one stage. The first expiry raises an interrupt level. The next raises a non-maskable interrupt level. The one after that issues a one-cycle soft-reset request.

Software keeps the block quiet by pulsing the poke input. A poke reloads the count and drops the block back to idle. A readback of mode, length and stage lets an NMI handler check whether the watchdog caused the NMI it is serving. The interrupt controller, the NMI logic and the reset controller sit outside this block.

Top module: `multi_stage_wdog`

## Requirements
- R1: After reset, the interrupt, NMI, soft-reset and NMI-pending outputs are low. The read-back mode, length and stage are all zero.
- R2: With a nonzero mode, the first expiry comes exactly len × 2^(LOW_BITS+PRE_LOG2) clock edges after the edge that captured the control write. The stage readback then changes from 0 (idle) to 1 (interrupt). Stage code 2 means NMI and code 3 means reset.
- R3: Each further period without a poke advances the stage by one. The interrupt level stays high while the NMI level is high.
- R4: The soft-reset request is high for exactly one cycle, on entry to stage 3. Later expiries keep stage 3 and do not pulse it again.
- R5: Mode encoding: 0 means disabled, 1 means interrupt only, 2 means interrupt then NMI, and 3 means all three stages. The stage never exceeds the mode. Once the last enabled stage is reached, the block holds there.
- R6: Mode 0 disables the block, with any length value. Writing mode 0 clears all stage outputs at once, and the outputs stay low from then on.
- R7: A poke returns the stage to idle on the next edge and restarts the count. The next expiry comes one full period after the poke.
- R8: A control write restarts the prescaler and the down-counter and clears the stage. The next expiry comes one full period after the latest write.
- R9: The read-back mode and length follow the last control write. The NMI-pending bit is high exactly when the stage is 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control write strobe |
| ctrlWrMode | input | 2 | Escalation mode to write |
| ctrlWrLen | input | LEN_W (16) | Period length to write |
| poke | input | 1 | Service strobe |
| rdMode | output | 2 | Current mode |
| rdLen | output | LEN_W (16) | Current length |
| rdStage | output | 2 | Current stage code |
| rdNmiPend | output | 1 | Watchdog NMI is pending |
| irqOut | output | 1 | Interrupt level |
| nmiOut | output | 1 | Non-maskable interrupt level |
| rstReqOut | output | 1 | One-cycle soft-reset request |

## Verification
Every result is timed from the clock edge that captures a write or a poke; call that edge E and the period T. Stage k appears after edge E+k·T and is visible at the following falling edge. The readback and the idle stage after a write or poke show one edge after E. The reset pulse lasts from edge E+3T to E+3T+1.

For each stimulus, the driver computes these edge numbers from the requirements and queues the expected vectors against a free-running edge count. The monitor compares each vector at the falling edge of its exact cycle. The cycle just before each expiry is also checked, so an off-by-one period cannot pass.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic [1:0] {
    STG_IDLE = 2'd0,
    STG_IRQ  = 2'd1,
    STG_NMI  = 2'd2,
    STG_RST  = 2'd3
  } wdStage_e;

  typedef struct packed {
    logic restart;
    logic run;
  } ctlStrobe_t;

endpackage

// File: rtl/wdg_datapath.sv
module wdg_datapath
  import wdg_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int LOW_BITS = 8,
  parameter int PRE_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strb,
  input  logic [LEN_W-1:0] loadLen,
  output logic             expire
);

  localparam int CNT_W = LEN_W + LOW_BITS;

  logic [PRE_LOG2-1:0] preQ;
  logic [CNT_W-1:0]    cntQ;
  logic [CNT_W-1:0]    loadVal;
  logic                tick;
  logic                atEnd;

  assign loadVal = {loadLen, {LOW_BITS{1'b0}}};
  assign tick    = strb.run & (&preQ);
  assign atEnd   = (cntQ >> 1) == '0;
  assign expire  = tick & atEnd & ~strb.restart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preQ <= '0;
      cntQ <= '0;
    end else if (strb.restart) begin
      preQ <= '0;
      cntQ <= loadVal;
    end else if (strb.run) begin
      preQ <= preQ + 1'b1;
      if (tick) cntQ <= atEnd ? loadVal : cntQ - 1'b1;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    !strb.restart |-> cntQ <= loadVal) else $error("count above load"); // R2
  AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> preQ == '0) else $error("prescaler not restarted"); // R8

endmodule

// File: rtl/wdg_control.sv
module wdg_control
  import wdg_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrMode,
  input  logic [LEN_W-1:0] wrLen,
  input  logic             poke,
  input  logic             expire,
  output ctlStrobe_t       strb,
  output logic [LEN_W-1:0] loadLen,
  output logic [1:0]       modeQ,
  output logic [LEN_W-1:0] lenQ,
  output wdStage_e         stageQ,
  output logic             rstReqQ
);

  logic canStep;

  assign strb.restart = wrEn | poke;
  assign strb.run     = modeQ != 2'd0;
  assign loadLen      = wrEn ? wrLen : lenQ;
  assign canStep      = 2'(stageQ) < modeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= 2'd0;
      lenQ    <= '0;
      stageQ  <= STG_IDLE;
      rstReqQ <= 1'b0;
    end else begin
      rstReqQ <= 1'b0;
      if (wrEn) begin
        modeQ  <= wrMode;
        lenQ   <= wrLen;
        stageQ <= STG_IDLE;
      end else if (poke) begin
        stageQ <= STG_IDLE;
      end else if (expire && canStep) begin
        stageQ <= wdStage_e'(stageQ + 2'd1);
        if (stageQ == STG_NMI) rstReqQ <= 1'b1;
      end
    end
  end

  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rstReqQ |=> !rstReqQ) else $error("reset request too long"); // R4
  AST_STAGE_CAP: assert property (@(posedge clk) disable iff (!rstN)
    2'(stageQ) <= modeQ) else $error("stage beyond mode"); // R5
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 2'd0) |-> (stageQ == STG_IDLE)) else $error("disabled not idle"); // R6
  AST_POKE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    poke |=> stageQ == STG_IDLE) else $error("poke kept stage"); // R7
  AST_STAGE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (stageQ == $past(stageQ) || stageQ == STG_IDLE ||
              2'(stageQ) == 2'($past(stageQ) + 2'd1))) else $error("stage jump"); // R3

endmodule

// File: rtl/multi_stage_wdog.sv
module multi_stage_wdog
  import wdg_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int LOW_BITS = 8,
  parameter int PRE_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWrEn,
  input  logic [1:0]       ctrlWrMode,
  input  logic [LEN_W-1:0] ctrlWrLen,
  input  logic             poke,
  output logic [1:0]       rdMode,
  output logic [LEN_W-1:0] rdLen,
  output logic [1:0]       rdStage,
  output logic             rdNmiPend,
  output logic             irqOut,
  output logic             nmiOut,
  output logic             rstReqOut
);

  ctlStrobe_t       strb;
  logic [LEN_W-1:0] loadLen;
  logic             expire;
  wdStage_e         stage;

  wdg_control #(.LEN_W(LEN_W)) uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (ctrlWrEn),
    .wrMode  (ctrlWrMode),
    .wrLen   (ctrlWrLen),
    .poke    (poke),
    .expire  (expire),
    .strb    (strb),
    .loadLen (loadLen),
    .modeQ   (rdMode),
    .lenQ    (rdLen),
    .stageQ  (stage),
    .rstReqQ (rstReqOut)
  );

  wdg_datapath #(.LEN_W(LEN_W), .LOW_BITS(LOW_BITS), .PRE_LOG2(PRE_LOG2)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .loadLen (loadLen),
    .expire  (expire)
  );

  assign rdStage   = stage;
  assign irqOut    = stage != STG_IDLE;
  assign nmiOut    = stage[1];
  assign rdNmiPend = stage[1];

endmodule

// File: tb/tb_multi_stage_wdog.sv
module tb_multi_stage_wdog;

  localparam int LEN_W = 16;
  localparam int LOWB  = 2;
  localparam int PREL  = 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             ctrlWrEn = 1'b0;
  logic [1:0]       ctrlWrMode = 2'd0;
  logic [LEN_W-1:0] ctrlWrLen = '0;
  logic             poke = 1'b0;
  logic [1:0]       rdMode;
  logic [LEN_W-1:0] rdLen;
  logic [1:0]       rdStage;
  logic             rdNmiPend, irqOut, nmiOut, rstReqOut;

  multi_stage_wdog #(.LEN_W(LEN_W), .LOW_BITS(LOWB), .PRE_LOG2(PREL)) dut (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrMode(ctrlWrMode),
    .ctrlWrLen(ctrlWrLen), .poke(poke), .rdMode(rdMode), .rdLen(rdLen),
    .rdStage(rdStage), .rdNmiPend(rdNmiPend), .irqOut(irqOut),
    .nmiOut(nmiOut), .rstReqOut(rstReqOut)
  );

  always #5 clk = ~clk;

  typedef struct {
    int          cyc;
    logic [23:0] exp;
    string       tag;
  } item_t;

  item_t sbQ[$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [23:0] mk(logic [1:0] m, logic [15:0] l, int stg, bit rst);
    logic [1:0] s;
    s = stg[1:0];
    return {m, l, s, s[1], s != 2'd0, s[1], rst};
  endfunction

  function automatic int per(int len);
    return len << (LOWB + PREL);
  endfunction

  task automatic push(int c, logic [23:0] e, string tag);
    item_t it;
    it.cyc = c; it.exp = e; it.tag = tag;
    sbQ.push_back(it);
  endtask

  always @(negedge clk) begin
    logic [23:0] act;
    item_t it;
    while (sbQ.size() > 0 && sbQ[0].cyc <= cyc) begin
      it = sbQ.pop_front();
      act = {rdMode, rdLen, rdStage, rdNmiPend, irqOut, nmiOut, rstReqOut};
      checks++;
      if (it.cyc != cyc || act !== it.exp) begin
        errors++;
        $display("FAIL %s cycle %0d: actual %h expected %h", it.tag, cyc, act, it.exp);
      end
    end
  end

  task automatic ctlWrite(logic [1:0] m, logic [15:0] l, output int w);
    @(negedge clk);
    ctrlWrEn = 1'b1; ctrlWrMode = m; ctrlWrLen = l;
    w = cyc + 1;
    @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  task automatic doPoke(output int p);
    @(negedge clk);
    poke = 1'b1;
    p = cyc + 1;
    @(negedge clk);
    poke = 1'b0;
  endtask

  task automatic waitTo(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic drain();
    while (sbQ.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int w, p, t;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    push(cyc + 1, mk(0, 0, 0, 0), "R1 reset state");
    drain();

    // R2 R3 R4 R9: full escalation, mode 3, len 3
    t = per(3);
    ctlWrite(2'd3, 16'd3, w);
    push(w + 1,       mk(3, 3, 0, 0), "R9 readback after write");
    push(w + t - 1,   mk(3, 3, 0, 0), "R2 idle before expiry");
    push(w + t,       mk(3, 3, 1, 0), "R2 first expiry");
    push(w + 2*t - 1, mk(3, 3, 1, 0), "R3 irq held");
    push(w + 2*t,     mk(3, 3, 2, 0), "R3 nmi stage, R9 pending");
    push(w + 3*t - 1, mk(3, 3, 2, 0), "R3 nmi held");
    push(w + 3*t,     mk(3, 3, 3, 1), "R4 reset pulse");
    push(w + 3*t + 1, mk(3, 3, 3, 0), "R4 pulse one cycle");
    push(w + 4*t,     mk(3, 3, 3, 0), "R4 no repeat pulse");
    drain();

    // R6: disable from stage 3
    ctlWrite(2'd0, 16'd0, w);
    push(w + 1,   mk(0, 0, 0, 0), "R6 disable clears");
    push(w + 100, mk(0, 0, 0, 0), "R6 stays disabled");
    drain();

    // R5: mode 1
    t = per(1);
    ctlWrite(2'd1, 16'd1, w);
    push(w + t,     mk(1, 1, 1, 0), "R5 mode1 irq");
    push(w + 2*t,   mk(1, 1, 1, 0), "R5 mode1 holds");
    push(w + 3*t,   mk(1, 1, 1, 0), "R5 mode1 no reset");
    drain();

    // R5: mode 2
    t = per(2);
    ctlWrite(2'd2, 16'd2, w);
    push(w + 2*t,   mk(2, 2, 2, 0), "R5 mode2 nmi");
    push(w + 3*t,   mk(2, 2, 2, 0), "R5 mode2 no reset");
    drain();

    // R7: poke after irq
    t = per(2);
    ctlWrite(2'd3, 16'd2, w);
    push(w + t, mk(3, 2, 1, 0), "R7 irq before poke");
    waitTo(w + t + 5);
    doPoke(p);
    push(p + 1,     mk(3, 2, 0, 0), "R7 poke clears");
    push(p + t - 1, mk(3, 2, 0, 0), "R7 idle until period");
    push(p + t,     mk(3, 2, 1, 0), "R7 expiry after poke");
    drain();
    doPoke(p);
    waitTo(p + 10);
    doPoke(p);
    push(p + t - 1, mk(3, 2, 0, 0), "R7 early poke keeps idle");
    push(p + t,     mk(3, 2, 1, 0), "R7 expiry after early poke");
    drain();

    // R6: mode 0 with nonzero length
    ctlWrite(2'd0, 16'd5, w);
    push(w + 1,   mk(0, 5, 0, 0), "R6 mode0 len5 idle");
    push(w + 200, mk(0, 5, 0, 0), "R6 mode0 no count");
    drain();

    // R8: rewrite restarts count
    t = per(2);
    ctlWrite(2'd3, 16'd2, w);
    waitTo(w + 20);
    ctlWrite(2'd3, 16'd2, w);
    push(w + t - 1, mk(3, 2, 0, 0), "R8 restart delays expiry");
    push(w + t,     mk(3, 2, 1, 0), "R8 expiry after rewrite");
    drain();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule